// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

A bank of eight single-bit ownership tokens shared by a left and a right port. Each port has its own semaphore enable, separate from any memory space, a 3-bit flag select, a write enable and a write data bit. A port asks for a token by writing 0 to it and gives it back by writing 1. It reads a status bit to learn whether it holds the token. The tokens control no hardware. Software uses them to agree on who may touch a shared resource, and no access to the bank ever stalls either port.

Each token keeps one request latch per port and one owner. A request made while the other port holds the token stays pending. The token moves to the waiting port on the clock edge at which the holder lets it go. If both ports ask for a free token in the same cycle, the left port wins and the right port's request waits. Writes take effect on the next rising clock edge. The status output is a combinational read of the current state.

Top module: `sem_token_bank`

## Requirements
- R1: Each of the eight tokens is picked by the 3-bit select (value n addresses token n), and every token keeps its own owner, apart from the others.
- R2: A write of data 0 with the enable high claims a free token on the next edge. From then on, the status reads 0 at the claiming port and 1 at the other port.
- R3: A write of data 1 from the holder releases the token on the next edge. With nothing pending, both ports then read 1.
- R4: A token never has two owners, so both ports never read 0 for the same token.
- R5: With the enable low, a port's write and data are ignored, no token changes, and its status output is 1.
- R6: A claim on a token held by the other port stays pending. The requester becomes the owner on the same edge at which the holder's release is taken.
- R7: Claims from both ports on the same free token in one cycle make the left port the owner, and the right claim stays pending.
- R8: After reset every token is free, no claim is pending, and enabled reads return 1 at both ports.
- R9: A write of 1 from a port that does not hold the token cancels that port's pending claim and leaves the holder unchanged.
- R10: An enabled read (write enable low) changes no token state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| leftSemEn | input | 1 | Left port token-bank enable, active high |
| leftSel | input | 3 | Left port token select |
| leftWrEn | input | 1 | Left port write enable, active high |
| leftWrData | input | 1 | Left port write bit (0 claims, 1 releases) |
| leftFlag | output | 1 | Left port status (0 means the left port holds the token) |
| rightSemEn | input | 1 | Right port token-bank enable, active high |
| rightSel | input | 3 | Right port token select |
| rightWrEn | input | 1 | Right port write enable, active high |
| rightWrData | input | 1 | Right port write bit (0 claims, 1 releases) |
| rightFlag | output | 1 | Right port status (0 means the right port holds the token) |

## Verification
Two things can fall in the same cycle. Both ports can claim one free token, or the holder's release can land on the same edge as the other port's pending claim. Directed sequences set up each case. A random phase then restricts the selects to a few tokens so that collisions, releases and pending claims pile up. Every cycle, the bench compares both status outputs with a token model it updates from the requirements. It also checks that both ports never read 0 for the same token.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int SEM_FLAGS = 8;
  localparam int SEM_SEL_W = $clog2(SEM_FLAGS);

  // per-token strobes from control to datapath
  typedef struct packed {
    logic [SEM_FLAGS-1:0] claimLeft;
    logic [SEM_FLAGS-1:0] dropLeft;
    logic [SEM_FLAGS-1:0] claimRight;
    logic [SEM_FLAGS-1:0] dropRight;
  } semStrobe_t;
endpackage

// File: rtl/sem_token_ctrl.sv
module sem_token_ctrl
  import sem_pkg::*;
(
  input  logic                 leftSemEn,
  input  logic [SEM_SEL_W-1:0] leftSel,
  input  logic                 leftWrEn,
  input  logic                 leftWrData,
  input  logic                 rightSemEn,
  input  logic [SEM_SEL_W-1:0] rightSel,
  input  logic                 rightWrEn,
  input  logic                 rightWrData,
  input  logic [SEM_FLAGS-1:0] ownLeft,
  input  logic [SEM_FLAGS-1:0] ownRight,
  output semStrobe_t           strb,
  output logic                 leftFlag,
  output logic                 rightFlag
);
  logic leftWrite, rightWrite;

  assign leftWrite  = leftSemEn && leftWrEn;
  assign rightWrite = rightSemEn && rightWrEn;

  // decode each port's write into one strobe per token
  always_comb begin
    strb = '0;
    for (int i = 0; i < SEM_FLAGS; i++) begin
      if (leftWrite && leftSel == SEM_SEL_W'(i)) begin
        strb.claimLeft[i] = !leftWrData;
        strb.dropLeft[i]  = leftWrData;
      end
      if (rightWrite && rightSel == SEM_SEL_W'(i)) begin
        strb.claimRight[i] = !rightWrData;
        strb.dropRight[i]  = rightWrData;
      end
    end
  end

  // status readback: 0 only to the holder; idle ports read 1
  assign leftFlag  = leftSemEn  ? !ownLeft[leftSel]   : 1'b1;
  assign rightFlag = rightSemEn ? !ownRight[rightSel] : 1'b1;

  // R4: both ports never see the same token as held
  always_comb begin
    if (leftSemEn && rightSemEn && leftSel == rightSel)
      a_no_double_read_r4: assert (leftFlag || rightFlag);
  end
endmodule

// File: rtl/sem_token_dp.sv
module sem_token_dp
  import sem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t           strb,
  output logic [SEM_FLAGS-1:0] ownLeft,
  output logic [SEM_FLAGS-1:0] ownRight
);
  logic [SEM_FLAGS-1:0] reqLeft, reqRight;

  for (genvar gi = 0; gi < SEM_FLAGS; gi++) begin : g_token
    logic reqLeftNext, reqRightNext;
    logic keepLeft, keepRight;
    logic ownLeftNext, ownRightNext;

    always_comb begin
      reqLeftNext  = strb.claimLeft[gi]  || (reqLeft[gi]  && !strb.dropLeft[gi]);
      reqRightNext = strb.claimRight[gi] || (reqRight[gi] && !strb.dropRight[gi]);
      keepLeft     = ownLeft[gi]  && reqLeftNext;
      keepRight    = ownRight[gi] && reqRightNext;
      // free token: left claim first, then right
      ownLeftNext  = keepLeft  || (!keepRight && reqLeftNext);
      ownRightNext = keepRight || (!keepLeft && !reqLeftNext && reqRightNext);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqLeft[gi]  <= 1'b0;
        reqRight[gi] <= 1'b0;
        ownLeft[gi]  <= 1'b0;
        ownRight[gi] <= 1'b0;
      end else begin
        reqLeft[gi]  <= reqLeftNext;
        reqRight[gi] <= reqRightNext;
        ownLeft[gi]  <= ownLeftNext;
        ownRight[gi] <= ownRightNext;
      end
    end

    p_single_owner_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(ownLeft[gi] && ownRight[gi]));

    p_reset_free_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstN) |-> (!ownLeft[gi] && !ownRight[gi] && !reqLeft[gi] && !reqRight[gi]));

    p_left_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!ownLeft[gi] && !ownRight[gi] && strb.claimLeft[gi] && strb.claimRight[gi])
        |=> (ownLeft[gi] && reqRight[gi]));

    p_handoff_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ownLeft[gi] && strb.dropLeft[gi] && reqRight[gi] && !strb.dropRight[gi])
        |=> ownRight[gi]);

    p_quiet_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.claimLeft[gi] && !strb.dropLeft[gi] && !strb.claimRight[gi] && !strb.dropRight[gi])
        |=> ($stable(ownLeft[gi]) && $stable(ownRight[gi])));

    p_holder_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ownLeft[gi] && !strb.dropLeft[gi]) |=> ownLeft[gi]);
  end
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank
  import sem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 leftSemEn,
  input  logic [SEM_SEL_W-1:0] leftSel,
  input  logic                 leftWrEn,
  input  logic                 leftWrData,
  output logic                 leftFlag,
  input  logic                 rightSemEn,
  input  logic [SEM_SEL_W-1:0] rightSel,
  input  logic                 rightWrEn,
  input  logic                 rightWrData,
  output logic                 rightFlag
);
  semStrobe_t           strb;
  logic [SEM_FLAGS-1:0] ownLeft, ownRight;

  sem_token_ctrl u_ctrl (
    .leftSemEn  (leftSemEn),
    .leftSel    (leftSel),
    .leftWrEn   (leftWrEn),
    .leftWrData (leftWrData),
    .rightSemEn (rightSemEn),
    .rightSel   (rightSel),
    .rightWrEn  (rightWrEn),
    .rightWrData(rightWrData),
    .ownLeft    (ownLeft),
    .ownRight   (ownRight),
    .strb       (strb),
    .leftFlag   (leftFlag),
    .rightFlag  (rightFlag)
  );

  sem_token_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ownLeft (ownLeft),
    .ownRight(ownRight)
  );
endmodule

// File: tb/sem_token_bank_bench.sv
module sem_token_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lEn = 1'b0, lWr = 1'b0, lDat = 1'b0;
  logic rEn = 1'b0, rWr = 1'b0, rDat = 1'b0;
  logic [2:0] lSel = '0, rSel = '0;
  logic lFlag, rFlag;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  bit [7:0] mReqL = '0, mReqR = '0, mOwnL = '0, mOwnR = '0;

  always #10 clk = ~clk;

  sem_token_bank u_sem_token_bank (
    .clk(clk), .rstN(rstN),
    .leftSemEn(lEn), .leftSel(lSel), .leftWrEn(lWr), .leftWrData(lDat), .leftFlag(lFlag),
    .rightSemEn(rEn), .rightSel(rSel), .rightWrEn(rWr), .rightWrData(rDat), .rightFlag(rFlag)
  );

  function automatic bit expStatus(bit en, bit [2:0] sel, bit [7:0] own);
    return en ? !own[sel] : 1'b1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // token rules: write sets/clears the claim, holder leaves when its claim goes,
  // a free token goes to the left claim first, then the right
  task automatic modelStep(bit eL, bit [2:0] sL, bit wL, bit dL,
                           bit eR, bit [2:0] sR, bit wR, bit dR);
    if (eL && wL) mReqL[sL] = !dL;
    if (eR && wR) mReqR[sR] = !dR;
    for (int f = 0; f < 8; f++) begin
      if (mOwnL[f] && !mReqL[f]) mOwnL[f] = 1'b0;
      if (mOwnR[f] && !mReqR[f]) mOwnR[f] = 1'b0;
      if (!mOwnL[f] && !mOwnR[f]) begin
        if (mReqL[f]) mOwnL[f] = 1'b1;
        else if (mReqR[f]) mOwnR[f] = 1'b1;
      end
    end
  endtask

  task automatic access(string tag,
                        bit eL, bit [2:0] sL, bit wL, bit dL,
                        bit eR, bit [2:0] sR, bit wR, bit dR);
    @(negedge clk);
    lEn = eL; lSel = sL; lWr = wL; lDat = dL;
    rEn = eR; rSel = sR; rWr = wR; rDat = dR;
    #2;
    chk({tag, " left"}, lFlag, expStatus(eL, sL, mOwnL));
    chk({tag, " right"}, rFlag, expStatus(eR, sR, mOwnR));
    if (eL && eR && sL == sR) chk("R4 not both held", lFlag | rFlag, 1'b1);
    @(posedge clk);
    #1;
    modelStep(eL, sL, wL, dL, eR, sR, wR, dR);
  endtask

  task automatic readBoth(string tag, bit [2:0] s);
    access(tag, 1, s, 0, 0, 1, s, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R8: reset state, R10: reads do not disturb
    for (int f = 0; f < 8; f++) readBoth("R8 reset free", 3'(f));

    // R2: left claims token 3
    access("R2 claim", 1, 3, 1, 0, 0, 0, 0, 0);
    readBoth("R2 held by left", 3);
    // R6: right claims token 3, stays pending
    access("R6 request", 0, 0, 0, 0, 1, 3, 1, 0);
    readBoth("R6 pending", 3);
    // R5: idle ports ignore writes; left idle reads 1 despite holding 3
    access("R5 idle", 0, 5, 1, 0, 0, 5, 1, 0);
    access("R5 idle holder", 0, 3, 0, 0, 1, 5, 0, 0);
    readBoth("R5 untouched", 5);
    // R6: release hands token 3 to right
    access("R6 release", 1, 3, 1, 1, 0, 0, 0, 0);
    readBoth("R6 handoff", 3);
    access("R3 release", 0, 0, 0, 0, 1, 3, 1, 1);
    readBoth("R3 free", 3);

    // R7: same-cycle claims on token 6
    access("R7 both claim", 1, 6, 1, 0, 1, 6, 1, 0);
    readBoth("R7 left wins", 6);
    access("R7 left drop", 1, 6, 1, 1, 0, 0, 0, 0);
    readBoth("R7 right gets", 6);
    access("R3 right drop", 0, 0, 0, 0, 1, 6, 1, 1);
    readBoth("R3 free again", 6);

    // R9: cancel pending claim
    access("R9 claim", 1, 1, 1, 0, 0, 0, 0, 0);
    access("R9 req", 0, 0, 0, 0, 1, 1, 1, 0);
    access("R9 cancel", 0, 0, 0, 0, 1, 1, 1, 1);
    readBoth("R9 holder kept", 1);
    access("R9 drop", 1, 1, 1, 1, 0, 0, 0, 0);
    readBoth("R9 stays free", 1);

    // R1: independent tokens
    for (int f = 0; f < 8; f++)
      access("R1 claim", f[0] ? 1'b0 : 1'b1, 3'(f), 1, 0, f[0], 3'(f), 1, 0);
    for (int f = 0; f < 8; f++) readBoth("R1 per token", 3'(f));
    for (int f = 0; f < 8; f++) access("R3 drop all", 1, 3'(f), 1, 1, 1, 3'(f), 1, 1);
    for (int f = 0; f < 8; f++) readBoth("R3 all free", 3'(f));

    // random phase, selects narrowed to force collisions
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      bit [2:0] sa, sb;
      sa = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      sb = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      access("R6 random", ($urandom % 4) != 0, sa, 1'($urandom), 1'($urandom),
             ($urandom % 4) != 0, sb, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule